// File: doc/BRIEF.md
# Twin-Predicated Compress/Expand Sequencer

This block sequences one single-source, single-destination operation over a vector of elements under two separate predicate masks: one filters the source elements, the other selects the destination slots. It keeps one element index per side. Each index jumps forward to the next element whose own mask bit is set. The two are then paired in order, and for each pairing the block presents a source register number and a destination register number with a one-cycle strobe. The per-element operation, such as a move or a width conversion, is done by logic outside this block, driven by that strobe.

The pairing scheme covers several common patterns. With a full destination mask it compresses the selected sources into consecutive destinations. With a full source mask it expands consecutive sources into the selected destinations. A scalar source with a vector destination broadcasts (splat), or inserts when the destination mask has one bit set. A vector source with a scalar destination selects a single element. The controller has two states. IDLE waits for a start pulse, latches the configuration and moves to RUN. RUN issues at most one pairing per clock and goes back to IDLE on the cycle it pulses `done`.

Top module: `twinpred_seq`

## Requirements
- R1: After reset, `busy`, `xfer_valid` and `done` are 0 and `xfer_count` is 0. A `start` pulse seen in IDLE latches all configuration inputs, clears `xfer_count`, and puts the block in RUN (`busy`=1) from the next cycle.
- R2: When the source is tagged vector, the source index moves to the lowest set bit of the source mask at or above its current value before each pairing.
- R3: When the destination is tagged vector, the destination index moves to the lowest set bit of the destination mask at or above its current value, independently of the source side.
- R4: A scalar-tagged operand ignores its mask. Its index stays 0, so every pairing uses its base register.
- R5: After a pairing, each vector-tagged index is set to one past the element it just used.
- R6: A scalar-tagged destination ends the run after its first pairing. `done` is 1 in the same cycle as that pairing's strobe.
- R7: If either index, after skipping, is at or beyond VL (or no set bit remains), the run ends with `done`=1, `xfer_valid`=0 for that one cycle, and a return to IDLE. VL=0 ends with no pairing.
- R8: At most one pairing is issued per clock while in RUN. `xfer_src` = source base + source index and `xfer_dst` = destination base + destination index, both modulo 2^REG_W.
- R9: `xfer_count` equals the number of pairings issued since the last accepted start, and it holds that value in IDLE.
- R10: While in RUN, `start` and all configuration inputs are ignored. The running sequence and its outputs are unchanged.
- R11: A VL input greater than MAX_VL is treated as MAX_VL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a sequence (accepted in IDLE only) |
| vl | input | $clog2(MAX_VL+1) | Vector length |
| src_mask | input | MAX_VL | Source predicate, bit k governs element k |
| dst_mask | input | MAX_VL | Destination predicate, bit k governs element k |
| src_base | input | REG_W | Source base register number |
| dst_base | input | REG_W | Destination base register number |
| src_vec | input | 1 | 1 = source tagged vector, 0 = scalar |
| dst_vec | input | 1 | 1 = destination tagged vector, 0 = scalar |
| busy | output | 1 | 1 while in RUN |
| xfer_valid | output | 1 | Pairing strobe for this cycle |
| xfer_src | output | REG_W | Source register number of the pairing |
| xfer_dst | output | REG_W | Destination register number of the pairing |
| done | output | 1 | One-cycle pulse on the last RUN cycle |
| xfer_count | output | $clog2(MAX_VL+1) | Pairings issued in the current or last run |

## Verification
The bench builds the block with MAX_VL=16 and REG_W=7. Sixteen elements give room for sparse masks on both sides, several set bits beyond a short VL, and a VL input of 25 to exercise the clamp. A base of 126 with a 7-bit register number makes the modulo wrap of register numbers visible within a single run. During every run the bench keeps pulsing start and changing the configuration inputs, so each compared cycle also shows that the latched configuration is held.

// File: rtl/twinpred_pkg.sv
package twinpred_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_t;

    localparam int LANE_SRC = 0;
    localparam int LANE_DST = 1;
    localparam int N_LANES  = 2;
endpackage

// File: rtl/tp_next_set.sv
// Lowest set mask bit at or above a start position; a scalar lane
// passes the position through untouched.
module tp_next_set #(
    parameter int N  = 16,
    parameter int IW = 5
) (
    input  logic [N-1:0]  mask,
    input  logic [IW-1:0] pos,
    input  logic          is_vec,
    output logic [IW-1:0] hit,
    output logic          found
);
    always_comb begin
        found = 1'b0;
        hit   = pos;
        if (!is_vec) begin
            found = 1'b1;
        end else begin
            // descending scan: the lowest qualifying bit is written last
            for (int k = N - 1; k >= 0; k--) begin
                if (mask[k] && (k >= int'(pos))) begin
                    found = 1'b1;
                    hit   = IW'(k);
                end
            end
        end
    end
endmodule

// File: rtl/tp_xfer_count.sv
module tp_xfer_count #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          inc,
    output logic [CW-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     count <= '0;
        else if (clear) count <= '0;
        else if (inc)   count <= count + CW'(1);
    end
endmodule

// File: rtl/twinpred_seq.sv
module twinpred_seq
    import twinpred_pkg::*;
#(
    parameter int MAX_VL = 16,
    parameter int REG_W  = 7,
    localparam int IW    = $clog2(MAX_VL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [IW-1:0]     vl,
    input  logic [MAX_VL-1:0] src_mask,
    input  logic [MAX_VL-1:0] dst_mask,
    input  logic [REG_W-1:0]  src_base,
    input  logic [REG_W-1:0]  dst_base,
    input  logic              src_vec,
    input  logic              dst_vec,
    output logic              busy,
    output logic              xfer_valid,
    output logic [REG_W-1:0]  xfer_src,
    output logic [REG_W-1:0]  xfer_dst,
    output logic              done,
    output logic [IW-1:0]     xfer_count
);
    seq_state_t state_q, state_d;

    logic [IW-1:0]                     vl_q;
    logic [N_LANES-1:0][MAX_VL-1:0]    mask_q;
    logic [N_LANES-1:0][REG_W-1:0]     base_q;
    logic [N_LANES-1:0]                vec_q;
    logic [N_LANES-1:0][IW-1:0]        idx_q;
    logic [N_LANES-1:0][IW-1:0]        hit;
    logic [N_LANES-1:0]                found;
    logic [N_LANES-1:0]                lane_ok;
    logic                              pair_ok;
    logic                              accept;
    logic [IW-1:0]                     vl_eff;

    assign accept = (state_q == ST_IDLE) && start;
    assign vl_eff = (int'(vl) > MAX_VL) ? IW'(MAX_VL) : vl;

    // per-lane skip logic and index registers
    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        tp_next_set #(.N(MAX_VL), .IW(IW)) u_find (
            .mask   (mask_q[g]),
            .pos    (idx_q[g]),
            .is_vec (vec_q[g]),
            .hit    (hit[g]),
            .found  (found[g])
        );

        assign lane_ok[g] = found[g] && (hit[g] < vl_q);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                idx_q[g] <= '0;
            end else if (accept) begin
                idx_q[g] <= '0;
            end else if (state_q == ST_RUN && pair_ok && vec_q[g]) begin
                idx_q[g] <= hit[g] + IW'(1);
            end
        end
    end

    assign pair_ok = &lane_ok;

    // configuration capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vl_q   <= '0;
            mask_q <= '0;
            base_q <= '0;
            vec_q  <= '0;
        end else if (accept) begin
            vl_q             <= vl_eff;
            mask_q[LANE_SRC] <= src_mask;
            mask_q[LANE_DST] <= dst_mask;
            base_q[LANE_SRC] <= src_base;
            base_q[LANE_DST] <= dst_base;
            vec_q[LANE_SRC]  <= src_vec;
            vec_q[LANE_DST]  <= dst_vec;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d    = state_q;
        busy       = 1'b0;
        xfer_valid = 1'b0;
        done       = 1'b0;
        xfer_src   = base_q[LANE_SRC] + REG_W'(hit[LANE_SRC]);
        xfer_dst   = base_q[LANE_DST] + REG_W'(hit[LANE_DST]);
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = ST_RUN;
            end
            ST_RUN: begin
                busy       = 1'b1;
                xfer_valid = pair_ok;
                done       = !pair_ok || !vec_q[LANE_DST];
                if (done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    tp_xfer_count #(.CW(IW)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (accept),
        .inc   (xfer_valid),
        .count (xfer_count)
    );
endmodule

// File: rtl/twinpred_seq_chk.sv
module twinpred_seq_chk #(
    parameter int MAX_VL = 16,
    parameter int REG_W  = 7,
    localparam int IW    = $clog2(MAX_VL + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              xfer_valid,
    input logic              done,
    input logic [IW-1:0]     xfer_count
);
    // R8
    strobe_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid |-> busy);

    // R7
    done_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R9
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && xfer_valid) |=> (xfer_count == $past(xfer_count) + IW'(1)));

    // R1
    count_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && xfer_count == '0));

    // R10
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    // R9
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(xfer_count));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
endmodule

bind twinpred_seq twinpred_seq_chk #(.MAX_VL(MAX_VL), .REG_W(REG_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .xfer_valid (xfer_valid),
    .done       (done),
    .xfer_count (xfer_count)
);

// File: tb/twinpred_seq_tb.sv
module twinpred_seq_tb;
    localparam int MAX_VL = 16;
    localparam int REG_W  = 7;
    localparam int IW     = $clog2(MAX_VL + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [IW-1:0]     vl = '0;
    logic [MAX_VL-1:0] src_mask = '0, dst_mask = '0;
    logic [REG_W-1:0]  src_base = '0, dst_base = '0;
    logic              src_vec = 1'b0, dst_vec = 1'b0;
    logic              busy, xfer_valid, done;
    logic [REG_W-1:0]  xfer_src, xfer_dst;
    logic [IW-1:0]     xfer_count;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #10 clk = ~clk;

    twinpred_seq #(.MAX_VL(MAX_VL), .REG_W(REG_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .vl(vl),
        .src_mask(src_mask), .dst_mask(dst_mask),
        .src_base(src_base), .dst_base(dst_base),
        .src_vec(src_vec), .dst_vec(dst_vec),
        .busy(busy), .xfer_valid(xfer_valid), .xfer_src(xfer_src),
        .xfer_dst(xfer_dst), .done(done), .xfer_count(xfer_count)
    );

    // expected per-cycle events of one run
    int q_valid[$];
    int q_src[$];
    int q_dst[$];
    int q_done[$];

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic build_model(input int vli, input int ps, input int pd,
                               input int sb, input int db, input bit sv, input bit dv);
        int n, i, j;
        n = (vli > MAX_VL) ? MAX_VL : vli;
        i = 0; j = 0;
        q_valid.delete(); q_src.delete(); q_dst.delete(); q_done.delete();
        forever begin
            if (sv) while (i < n && !ps[i]) i++;
            if (dv) while (j < n && !pd[j]) j++;
            if (i >= n || j >= n) begin
                q_valid.push_back(0); q_src.push_back(-1); q_dst.push_back(-1); q_done.push_back(1);
                break;
            end
            q_valid.push_back(1);
            q_src.push_back((sb + i) % (1 << REG_W));
            q_dst.push_back((db + j) % (1 << REG_W));
            q_done.push_back(dv ? 0 : 1);
            if (!dv) break;
            if (sv) i++;
            j++;
        end
    endtask

    task automatic run_case(input string req, input int vli, input int ps, input int pd,
                            input int sb, input int db, input bit sv, input bit dv);
        int nx;
        build_model(vli, ps, pd, sb, db, sv, dv);
        nx = 0;
        @(negedge clk);
        vl = IW'(vli); src_mask = MAX_VL'(ps); dst_mask = MAX_VL'(pd);
        src_base = REG_W'(sb); dst_base = REG_W'(db); src_vec = sv; dst_vec = dv;
        start = 1'b1;
        @(negedge clk);
        for (int e = 0; e < q_valid.size(); e++) begin
            check(req, "busy", int'(busy), 1);
            check(req, "xfer_valid", int'(xfer_valid), q_valid[e]);
            check(req, "done", int'(done), q_done[e]);
            if (q_valid[e] == 1) begin
                check(req, "xfer_src", int'(xfer_src), q_src[e]);
                check(req, "xfer_dst", int'(xfer_dst), q_dst[e]);
                nx++;
            end
            // R10: disturb inputs while running; last cycle releases start
            if (e < q_valid.size() - 1) begin
                start = 1'b1;
                vl = IW'($urandom_range(0, MAX_VL));
                src_mask = MAX_VL'($urandom); dst_mask = MAX_VL'($urandom);
                src_base = REG_W'($urandom); dst_base = REG_W'($urandom);
                src_vec = 1'($urandom); dst_vec = 1'($urandom);
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        check(req, "busy after done", int'(busy), 0);
        check(req, "xfer_valid idle", int'(xfer_valid), 0);
        check("R9", "xfer_count", int'(xfer_count), nx);
        @(negedge clk);
        check("R9", "xfer_count held", int'(xfer_count), nx);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_fail++;
                $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
                $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "busy reset", int'(busy), 0);
        check("R1", "xfer_valid reset", int'(xfer_valid), 0);
        check("R1", "done reset", int'(done), 0);
        check("R1", "xfer_count reset", int'(xfer_count), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "busy idle", int'(busy), 0);

        // R2 compress: vector source skips, full destination
        run_case("R2", 12, 'h0A53, 'hFFFF, 10, 40, 1, 1);
        // R3 expand: full source, sparse destination
        run_case("R3", 14, 'hFFFF, 'h2481, 0, 64, 1, 1);
        // R5 both sparse, both vector
        run_case("R5", 16, 'hF0F0, 'h0FF0, 3, 80, 1, 1);
        // R4 splat: scalar source to all destination slots
        run_case("R4", 9, 'h0000, 'hFFFF, 17, 20, 0, 1);
        // R4 insert: scalar source, single destination bit
        run_case("R4", 10, 'h0000, 'h0040, 5, 50, 0, 1);
        // R6 select: vector source, scalar destination
        run_case("R6", 16, 'h0100, 'h0000, 30, 7, 1, 0);
        // R6 scalar to scalar
        run_case("R6", 4, 'h0000, 'h0000, 9, 11, 0, 0);
        // R7 vl of zero
        run_case("R7", 0, 'hFFFF, 'hFFFF, 1, 2, 1, 1);
        // R7 no source bit below vl
        run_case("R7", 6, 'hFFC0, 'hFFFF, 1, 2, 1, 1);
        // R7 destination runs out first
        run_case("R7", 16, 'hFFFF, 'h0005, 0, 0, 1, 1);
        // R8 register number wrap
        run_case("R8", 8, 'hFFFF, 'hFFFF, 126, 125, 1, 1);
        // R11 vl above maximum clamps
        run_case("R11", 25, 'hFFFF, 'hFFFF, 0, 100, 1, 1);
        // R6 scalar destination with nothing selected
        run_case("R6", 8, 'hFF00, 'h0000, 0, 0, 1, 0);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule